// File: doc/BRIEF.md
# Multicycle Execution Issue Interlock

This block sits in the decode stage of an in-order pipeline that feeds four execution units of differing depth: a single-cycle integer unit, a pipelined floating-point adder, a pipelined multiplier and an unpipelined divider. Every cycle it is offered at most one candidate instruction, described by a valid bit, a unit class, a destination register and two source registers. It raises `stall` when the candidate must be held in decode. Otherwise `issue` goes high, and the block records the consequences of that issue in its internal state.

Four hazards are detected. The first is a read of a register whose producer has not yet reached its forwarding point. The second is a write that would land before an older, longer operation writing the same register. The third is a divide offered while the divider is still occupied. The fourth is a completion that would share a write-back cycle with one already reserved. The state behind these checks is a countdown per register, a divider occupancy counter and a shift register of reserved write-back cycles. All of it is cleared by a synchronous active-high reset. Register reads happen in order in decode, so write-after-read needs no check.

Top module: `fp_issue_interlock`

## Requirements
- R1: Class encoding is 0 integer, 1 adder, 2 multiplier, 3 divider. An integer result has latency 0, so a consumer in the very next cycle is not stalled for it.
- R2: An adder result has latency 3. A consumer whose sources name that destination is stalled when it is offered 1 to 3 cycles after the producer issues, and is free from 4 cycles on.
- R3: A multiplier result has latency 6. Its consumer is stalled at gaps of 1 to 6 cycles and is free from 7 on.
- R4: A divider result has latency 24. Its consumer is stalled at gaps of 1 to 24 cycles and is free from 25 on.
- R5: The divider accepts a new divide only every 25 cycles. A divide offered 1 to 24 cycles after an issued divide stalls, and one offered 25 or more cycles later does not.
- R6: A candidate stalls when its destination has a pending write that completes no earlier than the candidate's own write, that is when the remaining countdown exceeds the candidate's latency.
- R7: The write of an instruction with latency L uses the write-back cycle L+1 cycles after issue. A candidate whose cycle is already reserved stalls, so an instruction issued k cycles after one of latency Lp conflicts when k plus its own latency equals Lp.
- R8: `stall` and `issue` are low whenever `cand_valid` is low, whatever the other candidate fields hold. `issue` is high exactly when a valid candidate is not stalled.
- R9: Reset clears every register countdown, the divider counter and all write-back reservations, so no hazard from before the reset survives it.
- R10: Writing a register that an earlier issued instruction only reads never stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Candidate instruction present |
| cand_cls | input | 2 | Unit class: 0 integer, 1 adder, 2 multiplier, 3 divider |
| cand_dst | input | 5 | Destination register index |
| cand_src_a | input | 5 | First source register index |
| cand_src_b | input | 5 | Second source register index |
| stall | output | 1 | Hold the candidate in decode this cycle |
| issue | output | 1 | Candidate leaves decode at the next edge |

## Verification
The assertions check the following on every cycle:
- every issued divide finds the divider idle, and its counter then runs down one step per cycle;
- no issue lands on a reserved write-back cycle;
- no issued instruction reads a register with a pending countdown;
- no issued instruction overtakes an older write to its destination;
- nothing is flagged without a valid candidate.

Only the bench's sweeps can show that the stall windows have the exact length of each unit's latency and initiation interval, and that write-back conflicts occur for every pair of classes at the right gap. The same holds for the effect of reset on pending state and for the absence of any write-after-read interlock.

// File: rtl/fp_issue_pkg.sv
package fp_issue_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } unit_cls_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fp_reg_scoreboard.sv
module fp_reg_scoreboard #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int TMR_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] dst,
  input  logic [TMR_W-1:0] cand_lat,
  input  logic             issue,
  output logic             raw_hit,
  output logic             waw_hit
);

  // Cycles remaining until each register's pending result can be forwarded
  logic [TMR_W-1:0] tmr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr[g] <= '0;
      end else if (issue && (dst == REG_W'(g))) begin
        tmr[g] <= cand_lat;
      end else if (tmr[g] != '0) begin
        tmr[g] <= tmr[g] - 1'b1;
      end
    end
  end

  always_comb begin
    raw_hit = (tmr[src_a] != '0) || (tmr[src_b] != '0);
    waw_hit = (tmr[dst] > cand_lat);
  end

  AST_RAW_SOURCES_READY: assert property (@(posedge clk) disable iff (rst)
    issue |-> (tmr[src_a] == '0) && (tmr[src_b] == '0)); // R2

  AST_WAW_ORDER_KEPT: assert property (@(posedge clk) disable iff (rst)
    issue |-> (tmr[dst] <= cand_lat)); // R6

endmodule

// File: rtl/fp_div_tracker.sv
module fp_div_tracker #(
  parameter int II_DIV = 25,
  parameter int CNT_W  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic div_issue,
  output logic div_busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (div_issue) begin
      cnt <= CNT_W'(II_DIV - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign div_busy = (cnt != '0);

  AST_DIV_IDLE_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    div_issue |-> (cnt == '0)); // R5

  AST_DIV_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5

endmodule

// File: rtl/fp_wb_reservation.sv
module fp_wb_reservation #(
  parameter int SLOT_N = 26,
  parameter int OFF_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] cand_off,
  input  logic             issue,
  output logic             slot_taken
);

  // Bit i set: a result is written back i cycles from now
  logic [SLOT_N-1:0] resv;
  logic [SLOT_N-1:0] resv_nxt;

  always_comb begin
    resv_nxt = resv >> 1;
    if (issue) begin
      resv_nxt = resv_nxt | (SLOT_N'(1) << (cand_off - 1'b1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resv <= '0;
    end else begin
      resv <= resv_nxt;
    end
  end

  assign slot_taken = resv[cand_off];

  AST_SLOT_FREE_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue |-> !resv[cand_off]); // R7

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import fp_issue_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LAT_INT  = 0,
  parameter int LAT_ADD  = 3,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIV  = 24,
  parameter int II_DIV   = 25,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cand_valid,
  input  logic [1:0]       cand_cls,
  input  logic [REG_W-1:0] cand_dst,
  input  logic [REG_W-1:0] cand_src_a,
  input  logic [REG_W-1:0] cand_src_b,
  output logic             stall,
  output logic             issue
);

  localparam int LAT_MAX = max_of4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);
  localparam int TMR_W   = $clog2(LAT_MAX + 1);
  localparam int SLOT_N  = LAT_MAX + 2;
  localparam int OFF_W   = $clog2(SLOT_N);
  localparam int CNT_W   = $clog2(II_DIV + 1);

  unit_cls_t        cls;
  logic [TMR_W-1:0] cand_lat;
  logic [OFF_W-1:0] cand_off;
  logic             is_div;
  logic             raw_hit;
  logic             waw_hit;
  logic             slot_taken;
  logic             div_busy;

  assign cls = unit_cls_t'(cand_cls);

  always_comb begin
    case (cls)
      CLS_INT: cand_lat = TMR_W'(LAT_INT);
      CLS_ADD: cand_lat = TMR_W'(LAT_ADD);
      CLS_MUL: cand_lat = TMR_W'(LAT_MUL);
      default: cand_lat = TMR_W'(LAT_DIV);
    endcase
  end

  assign cand_off = OFF_W'(cand_lat) + 1'b1;
  assign is_div   = (cls == CLS_DIV);

  fp_reg_scoreboard #(
    .NUM_REGS(NUM_REGS),
    .REG_W   (REG_W),
    .TMR_W   (TMR_W)
  ) u_scoreboard (
    .clk     (clk),
    .rst     (rst),
    .src_a   (cand_src_a),
    .src_b   (cand_src_b),
    .dst     (cand_dst),
    .cand_lat(cand_lat),
    .issue   (issue),
    .raw_hit (raw_hit),
    .waw_hit (waw_hit)
  );

  fp_div_tracker #(
    .II_DIV(II_DIV),
    .CNT_W (CNT_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .div_issue(issue && is_div),
    .div_busy (div_busy)
  );

  fp_wb_reservation #(
    .SLOT_N(SLOT_N),
    .OFF_W (OFF_W)
  ) u_wb (
    .clk       (clk),
    .rst       (rst),
    .cand_off  (cand_off),
    .issue     (issue),
    .slot_taken(slot_taken)
  );

  assign stall = cand_valid && (raw_hit || waw_hit || slot_taken || (is_div && div_busy));
  assign issue = cand_valid && !stall;

  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    !cand_valid |-> (!stall && !issue)); // R8

endmodule

// File: tb/fp_issue_interlock_bench.sv
module fp_issue_interlock_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cand_valid = 1'b0;
  logic [1:0] cand_cls = 2'd0;
  logic [4:0] cand_dst = 5'd0;
  logic [4:0] cand_src_a = 5'd0;
  logic [4:0] cand_src_b = 5'd0;
  logic       stall;
  logic       issue;

  int checks = 0;
  int errors = 0;

  fp_issue_interlock u_fp_issue_interlock (
    .clk       (clk),
    .rst       (rst),
    .cand_valid(cand_valid),
    .cand_cls  (cand_cls),
    .cand_dst  (cand_dst),
    .cand_src_a(cand_src_a),
    .cand_src_b(cand_src_b),
    .stall     (stall),
    .issue     (issue)
  );

  always #10 clk = ~clk;

  function automatic int lat_of(input int c);
    case (c)
      0: return 0;
      1: return 3;
      2: return 6;
      default: return 24;
    endcase
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic drive(input logic v, input int c, input int d, input int a, input int b);
    cand_valid = v;
    cand_cls   = 2'(c);
    cand_dst   = 5'(d);
    cand_src_a = 5'(a);
    cand_src_b = 5'(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    drive(1'b0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Issue producer, wait so the consumer is offered k cycles later, sample stall
  task automatic pair(input int pc, input int pd, input int cc, input int cd,
                      input int ca, input int cb, input int k, output logic got);
    do_reset();
    drive(1'b1, pc, pd, 1, 2);
    @(posedge clk);
    for (int j = 1; j < k; j++) begin
      @(negedge clk);
      drive(1'b0, 0, 0, 0, 0);
      @(posedge clk);
    end
    @(negedge clk);
    drive(1'b1, cc, cd, ca, cb);
    #2;
    got = stall;
    @(negedge clk);
    drive(1'b0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic got;
    string tag;

    do_reset();
    // R9: reset state, a divide reading anything is accepted
    drive(1'b1, 3, 5, 5, 6);
    #2;
    chk("R9", stall, 1'b0, "stall after reset");
    chk("R8", issue, 1'b1, "issue of free candidate");

    // RAW sweeps per producer class: stall iff gap <= latency
    for (int p = 0; p < 4; p++) begin
      tag = (p == 0) ? "R1" : (p == 1) ? "R2" : (p == 2) ? "R3" : "R4";
      for (int k = 1; k <= lat_of(p) + 2; k++) begin
        pair(p, 5, 0, 9, 5, 3, k, got);
        chk(tag, got, (k <= lat_of(p)), $sformatf("RAW class %0d gap %0d", p, k));
      end
    end

    // R5: divider initiation interval
    for (int k = 1; k <= 26; k++) begin
      pair(3, 5, 3, 9, 3, 4, k, got);
      chk("R5", got, (k <= 24), $sformatf("divide after divide gap %0d", k));
    end

    // R6: same destination, no source dependence
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        if (!(p == 3 && c == 3)) begin
          for (int k = 1; k <= 26; k++) begin
            if (k <= lat_of(p) + 1) begin
              pair(p, 5, c, 5, 3, 4, k, got);
              chk("R6", got,
                  ((lat_of(p) - k + 1) > lat_of(c)) || (k + lat_of(c) == lat_of(p)),
                  $sformatf("WAW p%0d c%0d gap %0d", p, c, k));
            end
          end
        end
      end
    end

    // R7: write-back slot conflicts between independent instructions
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        if (!(p == 3 && c == 3)) begin
          for (int k = 1; k <= 8; k++) begin
            pair(p, 5, c, 9, 3, 4, k, got);
            chk("R7", got, (k + lat_of(c) == lat_of(p)),
                $sformatf("slot p%0d c%0d gap %0d", p, c, k));
          end
        end
      end
    end

    // R8: invalid candidate with every hazard present
    do_reset();
    drive(1'b1, 3, 5, 1, 2);
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 3, 5, 5, 5);
    #2;
    chk("R8", stall, 1'b0, "stall with invalid candidate");
    chk("R8", issue, 1'b0, "issue with invalid candidate");
    drive(1'b1, 3, 5, 5, 5);
    #2;
    chk("R8", stall, 1'b1, "stall with same candidate valid");
    chk("R8", issue, 1'b0, "issue while stalled");

    // R9: pending divide state erased by reset
    do_reset();
    drive(1'b1, 0, 9, 5, 5);
    #2;
    chk("R9", stall, 1'b0, "read of pre-reset divide target");
    drive(1'b1, 3, 5, 3, 4);
    #2;
    chk("R9", stall, 1'b0, "divide and WAW after reset");

    // R10: write after read never stalls
    do_reset();
    drive(1'b1, 1, 8, 7, 6);
    @(posedge clk);
    @(negedge clk);
    drive(1'b1, 0, 7, 3, 4);
    #2;
    chk("R10", stall, 1'b0, "write of register read by adder");
    drive(1'b1, 2, 6, 3, 4);
    #2;
    chk("R10", stall, 1'b0, "write of second adder source");
    @(negedge clk);
    drive(1'b0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule